// File: doc/BRIEF.md
# Five-Stage In-Order Load/Store Pipeline

This block is a small integer core that moves every instruction through five clocked stages: fetch, decode, execute, memory access and writeback. A register between each pair of stages holds what the next stage needs. The core understands four operations: register add, register nand, word load and word store. It has eight general registers, and its instruction and data stores live inside the block as word arrays with clocked writes.

A program and its starting data are written through a preload port, normally while reset is held. After reset is released the core fetches one word per cycle from word 0 upward and finishes one instruction per cycle in steady state. The core has no interlock, no forwarding network and no control flow. The program must therefore place at least two unrelated instructions between an instruction and a later one that reads its result. Two debug ports show any register and any data word, so that results can be observed.

Top module: `pipe5_core`

## Requirements
- R1: While rst_n is low at a rising edge, the PC is set to 0, every stage register is set to an empty slot whose write enables are all zero, and all eight registers are set to 0. The data store is not cleared, and empty slots change neither registers nor data.
- R2: After reset is released, the word at instruction index k (byte address 4k) is fetched at the (k+1)-th rising edge. The PC then advances by 4 on every edge.
- R3: An instruction with opcode bits [31:26] = 0x00 and function bits [5:0] = 0x20 writes the sum of register rs (bits [25:21]) and register rt (bits [20:16]) to register rd (bits [15:11]).
- R4: Opcode 0x00 with function 0x27 writes ~(rs & rt) to rd.
- R5: Opcode 0x23 writes the data word at byte address rs + sext(bits [15:0]) to register rt.
- R6: Opcode 0x2B stores register rt to the data word at byte address rs + sext(bits [15:0]). Data addresses are byte addresses and must be word aligned, and data word n sits at byte address 4n.
- R7: Only the low three bits of each 5-bit register field select a register. Register 0 is an ordinary register that can be written and read.
- R8: An instruction fetched at the first edge after reset updates its destination register at the fifth edge. The instruction behind it updates its destination at the sixth edge.
- R9: A register written in writeback is seen by a decode in the same cycle, so an instruction placed three slots after its producer reads the new value.
- R10: Any other opcode, or opcode 0x00 with any other function code, changes no register and no data word.
- R11: The 16-bit offset is sign-extended, so negative offsets address below the base register.
- R12: While load_en is high at a rising edge, load_data is written to word load_addr of the instruction store (load_sel = 0) or of the data store (load_sel = 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| load_en | input | 1 | Preload write strobe |
| load_sel | input | 1 | Preload target: 0 instruction store, 1 data store |
| load_addr | input | MEM_AW | Preload word index |
| load_data | input | 32 | Preload word |
| dbg_reg_sel | input | 3 | Register to show |
| dbg_reg_val | output | 32 | Contents of the selected register |
| dbg_mem_addr | input | MEM_AW | Data word index to show |
| dbg_mem_val | output | 32 | Contents of the selected data word |

## Verification
The assertions assume that each data address a program produces is a multiple of four. They also assume that the program keeps dependent instructions at least three slots apart, because the core has no interlock and the write-through check only covers a producer that is exactly in writeback. The test program uses only word-aligned offsets from aligned base values and puts independent loads or nops between producers and their consumers. All preloading is done while reset is held, so a preload never meets a store in flight.

// File: rtl/pipe5_pkg.sv
// Shared types and encodings for the five-stage core.
// Assumes 32-bit instructions and eight architectural registers.
package pipe5_pkg;

    localparam int XLEN  = 32;
    localparam int RSEL  = 3;
    localparam int NREGS = 1 << RSEL;

    localparam logic [5:0] OP_REG   = 6'h00;
    localparam logic [5:0] OP_LOADW = 6'h23;
    localparam logic [5:0] OP_STORW = 6'h2B;
    localparam logic [5:0] FN_ADD   = 6'h20;
    localparam logic [5:0] FN_NAND  = 6'h27;

    // Control bits carried down the pipe; all-zero means an empty slot.
    typedef struct packed {
        logic reg_we;
        logic mem_rd;
        logic mem_we;
        logic use_imm;
        logic do_nand;
    } ctrl_t;

    typedef struct packed {
        logic [XLEN-1:0] inst;
        logic [XLEN-1:0] pc4;
    } ifid_t;

    typedef struct packed {
        ctrl_t           ctrl;
        logic [RSEL-1:0] dst;
        logic [XLEN-1:0] imm;
        logic [XLEN-1:0] a;
        logic [XLEN-1:0] b;
        logic [XLEN-1:0] pc4;
    } idex_t;

    typedef struct packed {
        ctrl_t           ctrl;
        logic [RSEL-1:0] dst;
        logic [XLEN-1:0] alu;
        logic [XLEN-1:0] sdata;
    } exmem_t;

    typedef struct packed {
        ctrl_t           ctrl;
        logic [RSEL-1:0] dst;
        logic [XLEN-1:0] mdata;
        logic [XLEN-1:0] alu;
    } memwb_t;

    // Map an instruction word to its control bits; unknown codes give an empty slot.
    function automatic ctrl_t decode_ctrl(input logic [XLEN-1:0] inst);
        ctrl_t c;
        c = '0;
        unique case (inst[31:26])
            OP_REG: begin
                if (inst[5:0] == FN_ADD) begin
                    c.reg_we = 1'b1;
                end else if (inst[5:0] == FN_NAND) begin
                    c.reg_we  = 1'b1;
                    c.do_nand = 1'b1;
                end
            end
            OP_LOADW: begin
                c.reg_we  = 1'b1;
                c.mem_rd  = 1'b1;
                c.use_imm = 1'b1;
            end
            OP_STORW: begin
                c.mem_we  = 1'b1;
                c.use_imm = 1'b1;
            end
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/pipe5_fetch.sv
// Fetch stage: program counter, instruction store and the fetch/decode register.
// Assumes the store is written only through the preload port; the PC wraps
// around the store because only its index bits address it.
module pipe5_fetch
    import pipe5_pkg::*;
#(
    parameter int MEM_AW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [MEM_AW-1:0] wr_addr,
    input  logic [XLEN-1:0]   wr_data,
    output ifid_t             ifid_o
);

    localparam int DEPTH = 1 << MEM_AW;

    logic [XLEN-1:0] imem [DEPTH];
    logic [XLEN-1:0] pc_q;
    logic [XLEN-1:0] pc_next;
    ifid_t           ifid_q;

    assign pc_next = pc_q + XLEN'(4);
    assign ifid_o  = ifid_q;

    // Preload write into the instruction store.
    always_ff @(posedge clk) begin
        if (wr_en) imem[wr_addr] <= wr_data;
    end

    // Advance the PC and capture the fetched word with its successor address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q   <= '0;
            ifid_q <= '0;
        end else begin
            pc_q        <= pc_next;
            ifid_q.inst <= imem[pc_q[MEM_AW+1:2]];
            ifid_q.pc4  <= pc_next;
        end
    end

    // R2
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> pc_q == $past(pc_q) + XLEN'(4));

endmodule

// File: rtl/pipe5_regfile.sv
// Eight-entry register file with two read ports, one write port and a debug port.
// A write in the current cycle is passed straight to the decode read ports.
module pipe5_regfile
    import pipe5_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [RSEL-1:0] ra_idx,
    input  logic [RSEL-1:0] rb_idx,
    output logic [XLEN-1:0] ra_val,
    output logic [XLEN-1:0] rb_val,
    input  logic            we,
    input  logic [RSEL-1:0] waddr,
    input  logic [XLEN-1:0] wdata,
    input  logic [RSEL-1:0] dbg_idx,
    output logic [XLEN-1:0] dbg_val
);

    logic [XLEN-1:0] regs [NREGS];

    // Clear on reset, otherwise take the writeback value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) regs[i] <= '0;
        end else if (we) begin
            regs[waddr] <= wdata;
        end
    end

    // Read ports with same-cycle write-through.
    always_comb begin
        ra_val  = (we && waddr == ra_idx) ? wdata : regs[ra_idx];
        rb_val  = (we && waddr == rb_idx) ? wdata : regs[rb_idx];
        dbg_val = regs[dbg_idx];
    end

    // R8
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> regs[$past(waddr)] == $past(wdata));

endmodule

// File: rtl/pipe5_dmem.sv
// Data store: combinational word read, clocked write from either the preload
// port (takes priority) or the memory stage. Assumes word-aligned addresses.
module pipe5_dmem
    import pipe5_pkg::*;
#(
    parameter int MEM_AW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pre_en,
    input  logic [MEM_AW-1:0] pre_addr,
    input  logic [XLEN-1:0]   pre_data,
    input  logic              we,
    input  logic [XLEN-1:0]   addr,
    input  logic [XLEN-1:0]   wdata,
    output logic [XLEN-1:0]   rdata,
    input  logic [MEM_AW-1:0] dbg_addr,
    output logic [XLEN-1:0]   dbg_val
);

    localparam int DEPTH = 1 << MEM_AW;

    logic [XLEN-1:0]   mem [DEPTH];
    logic [MEM_AW-1:0] widx;
    logic              unused_addr;

    assign widx        = addr[MEM_AW+1:2];
    assign rdata       = mem[widx];
    assign dbg_val     = mem[dbg_addr];
    assign unused_addr = ^{addr[XLEN-1:MEM_AW+2], addr[1:0]};

    // Word write from preload or from a store in the memory stage.
    always_ff @(posedge clk) begin
        if (pre_en)  mem[pre_addr] <= pre_data;
        else if (we) mem[widx]     <= wdata;
    end

    // R6
    aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> addr[1:0] == 2'b00);

endmodule

// File: rtl/pipe5_core.sv
// Five-stage in-order core: fetch, decode, execute, memory, writeback.
// Assumes software spaces dependent instructions three slots apart; there is
// no interlock or forwarding apart from the register file write-through.
module pipe5_core
    import pipe5_pkg::*;
#(
    parameter int MEM_AW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic              load_sel,
    input  logic [MEM_AW-1:0] load_addr,
    input  logic [XLEN-1:0]   load_data,
    input  logic [RSEL-1:0]   dbg_reg_sel,
    output logic [XLEN-1:0]   dbg_reg_val,
    input  logic [MEM_AW-1:0] dbg_mem_addr,
    output logic [XLEN-1:0]   dbg_mem_val
);

    ifid_t           ifid;
    idex_t           idex_q;
    exmem_t          exmem_q;
    memwb_t          memwb_q;
    ctrl_t           dec_ctrl;
    logic [RSEL-1:0] rs_idx, rt_idx, rd_idx, dec_dst;
    logic [XLEN-1:0] rf_a, rf_b, dec_imm;
    logic [XLEN-1:0] alu_b, alu_res, mem_rdata;
    logic            wb_we;
    logic [RSEL-1:0] wb_dst;
    logic [XLEN-1:0] wb_data;
    logic            unused_top;

    pipe5_fetch #(.MEM_AW(MEM_AW)) u_fetch (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (load_en && !load_sel),
        .wr_addr (load_addr),
        .wr_data (load_data),
        .ifid_o  (ifid)
    );

    // Field extraction and control decode.
    always_comb begin
        rs_idx   = ifid.inst[23:21];
        rt_idx   = ifid.inst[18:16];
        rd_idx   = ifid.inst[13:11];
        dec_ctrl = decode_ctrl(ifid.inst);
        dec_dst  = (ifid.inst[31:26] == OP_REG) ? rd_idx : rt_idx;
        dec_imm  = {{(XLEN-16){ifid.inst[15]}}, ifid.inst[15:0]};
    end

    pipe5_regfile u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .ra_idx  (rs_idx),
        .rb_idx  (rt_idx),
        .ra_val  (rf_a),
        .rb_val  (rf_b),
        .we      (wb_we),
        .waddr   (wb_dst),
        .wdata   (wb_data),
        .dbg_idx (dbg_reg_sel),
        .dbg_val (dbg_reg_val)
    );

    // Decode/execute register.
    always_ff @(posedge clk) begin
        if (!rst_n) idex_q <= '0;
        else        idex_q <= '{ctrl: dec_ctrl, dst: dec_dst, imm: dec_imm,
                                a: rf_a, b: rf_b, pc4: ifid.pc4};
    end

    // ALU: add for add/load/store, nand for nand.
    always_comb begin
        alu_b   = idex_q.ctrl.use_imm ? idex_q.imm : idex_q.b;
        alu_res = idex_q.ctrl.do_nand ? ~(idex_q.a & alu_b) : idex_q.a + alu_b;
    end

    // Execute/memory register.
    always_ff @(posedge clk) begin
        if (!rst_n) exmem_q <= '0;
        else        exmem_q <= '{ctrl: idex_q.ctrl, dst: idex_q.dst,
                                 alu: alu_res, sdata: idex_q.b};
    end

    pipe5_dmem #(.MEM_AW(MEM_AW)) u_dmem (
        .clk      (clk),
        .rst_n    (rst_n),
        .pre_en   (load_en && load_sel),
        .pre_addr (load_addr),
        .pre_data (load_data),
        .we       (exmem_q.ctrl.mem_we),
        .addr     (exmem_q.alu),
        .wdata    (exmem_q.sdata),
        .rdata    (mem_rdata),
        .dbg_addr (dbg_mem_addr),
        .dbg_val  (dbg_mem_val)
    );

    // Memory/writeback register.
    always_ff @(posedge clk) begin
        if (!rst_n) memwb_q <= '0;
        else        memwb_q <= '{ctrl: exmem_q.ctrl, dst: exmem_q.dst,
                                 mdata: mem_rdata, alu: exmem_q.alu};
    end

    // Writeback select.
    always_comb begin
        wb_we   = memwb_q.ctrl.reg_we;
        wb_dst  = memwb_q.dst;
        wb_data = memwb_q.ctrl.mem_rd ? memwb_q.mdata : memwb_q.alu;
    end

    assign unused_top = ^{ifid.inst[25:24], ifid.inst[20:19], idex_q.pc4,
                          memwb_q.ctrl.mem_we, memwb_q.ctrl.use_imm,
                          memwb_q.ctrl.do_nand};

    // R10
    ctrl_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({idex_q.ctrl.reg_we, idex_q.ctrl.mem_we}));

    // R5
    load_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idex_q.ctrl.mem_rd |-> idex_q.ctrl.reg_we);

    // R8
    ex_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idex_q.ctrl.reg_we |=> exmem_q.ctrl.reg_we && exmem_q.dst == $past(idex_q.dst));

    // R8
    mem_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exmem_q.ctrl.reg_we |=> memwb_q.ctrl.reg_we && memwb_q.dst == $past(exmem_q.dst));

    // R9
    wr_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_we && wb_dst == rs_idx) |=> idex_q.a == $past(wb_data));

endmodule

// File: tb/pipe5_core_bench.sv
`timescale 1ns/1ps
module pipe5_core_bench;

    localparam int MEM_AW = 6;
    localparam logic [5:0] T_LW = 6'h23, T_SW = 6'h2B;

    function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction

    // Program: loads, add, nand, register 0 as target, store, wide register fields, unknown codes.
    localparam logic [31:0] PROG [15] = '{
        enc_i(T_LW, 0, 1, 16'd0),        // r1 = 5
        enc_i(T_LW, 0, 2, 16'd4),        // r2 = 7
        enc_i(T_LW, 0, 3, 16'd8),        // r3 = ffff0000
        enc_i(T_LW, 0, 4, 16'd12),       // r4 = 12345678
        enc_i(T_LW, 0, 7, 16'd16),       // r7 = 100
        enc_r(1, 2, 5, 6'h20),           // r5 = 12
        enc_r(3, 4, 6, 6'h27),           // r6 = nand, r4 through write-through
        enc_r(1, 1, 0, 6'h20),           // r0 = 10
        32'h0000_0000,
        enc_i(T_SW, 7, 5, 16'hFFB0),     // mem[100-80] = 12
        enc_r(9, 8, 13, 6'h20),          // fields 9/8/13 -> r1/r0/r5 = 15
        enc_i(6'h3F, 0, 1, 16'd0),       // unknown opcode
        enc_r(1, 1, 2, 6'h11),           // unknown function
        enc_i(T_LW, 7, 3, 16'd20),       // r3 = mem[120]
        enc_i(T_LW, 7, 4, 16'hFFB0)      // r4 = mem[20]
    };
    localparam logic [31:0] EXP_REG [8] = '{
        32'd10, 32'd5, 32'd7, 32'hCAFEF00D, 32'd12, 32'd15, 32'hEDCBFFFF, 32'd100
    };
    string REG_TAG [8] = '{"R3 R7", "R5 R10", "R5 R10", "R5", "R11", "R7", "R4 R9", "R5"};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              load_en = 1'b0;
    logic              load_sel = 1'b0;
    logic [MEM_AW-1:0] load_addr = '0;
    logic [31:0]       load_data = '0;
    logic [2:0]        dbg_reg_sel = '0;
    logic [31:0]       dbg_reg_val;
    logic [MEM_AW-1:0] dbg_mem_addr = '0;
    logic [31:0]       dbg_mem_val;
    int                total = 0;
    int                bad = 0;
    logic              finished = 1'b0;

    always #4 clk = ~clk;

    pipe5_core #(.MEM_AW(MEM_AW)) u_pipe5_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_en      (load_en),
        .load_sel     (load_sel),
        .load_addr    (load_addr),
        .load_data    (load_data),
        .dbg_reg_sel  (dbg_reg_sel),
        .dbg_reg_val  (dbg_reg_val),
        .dbg_mem_addr (dbg_mem_addr),
        .dbg_mem_val  (dbg_mem_val)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd_reg(input int i, output logic [31:0] v);
        dbg_reg_sel = 3'(i);
        #1;
        v = dbg_reg_val;
    endtask

    task automatic rd_mem(input int i, output logic [31:0] v);
        dbg_mem_addr = MEM_AW'(i);
        #1;
        v = dbg_mem_val;
    endtask

    task automatic preload(input logic sel, input int addr, input logic [31:0] data);
        @(negedge clk);
        load_en   = 1'b1;
        load_sel  = sel;
        load_addr = MEM_AW'(addr);
        load_data = data;
        @(negedge clk);
        load_en = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R8 watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        // R1: registers cleared by reset
        for (int i = 0; i < 8; i++) begin
            rd_reg(i, v);
            check("R1 reset register", v, 32'd0);
        end

        // R12: preload data and program while reset is held
        preload(1'b1, 0, 32'd5);
        preload(1'b1, 1, 32'd7);
        preload(1'b1, 2, 32'hFFFF0000);
        preload(1'b1, 3, 32'h12345678);
        preload(1'b1, 4, 32'd100);
        preload(1'b1, 5, 32'd0);
        preload(1'b1, 30, 32'hCAFEF00D);
        for (int i = 0; i < 64; i++) preload(1'b0, i, (i < 15) ? PROG[i] : 32'd0);
        rd_mem(30, v);
        check("R12 data preload", v, 32'hCAFEF00D);
        rd_mem(2, v);
        check("R12 data preload", v, 32'hFFFF0000);

        // R8 R2: first result lands at the fifth edge, next one an edge later
        @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rd_reg(1, v);
        check("R8 before fifth edge", v, 32'd0);
        @(negedge clk);
        rd_reg(1, v);
        check("R8 at fifth edge", v, 32'd5);
        rd_reg(2, v);
        check("R2 second not yet", v, 32'd0);
        @(negedge clk);
        rd_reg(2, v);
        check("R2 R8 second at sixth edge", v, 32'd7);

        // Table walk over the final register state
        repeat (25) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rd_reg(i, v);
            check(REG_TAG[i], v, EXP_REG[i]);
        end
        rd_mem(5, v);
        check("R6 R9 R11 stored word", v, 32'd12);
        rd_mem(0, v);
        check("R6 untouched word", v, 32'd5);

        // R1: reset mid-run clears registers, keeps data
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rd_reg(i, v);
            check("R1 reset mid-run", v, 32'd0);
        end
        rd_mem(5, v);
        check("R1 data kept over reset", v, 32'd12);

        // R10: unknown encodings change nothing
        preload(1'b0, 0, enc_i(6'h3F, 0, 1, 16'd4));
        preload(1'b0, 1, enc_r(1, 1, 2, 6'h11));
        preload(1'b0, 2, enc_r(0, 0, 3, 6'h00));
        preload(1'b0, 3, enc_i(6'h2A, 0, 7, 16'd20));
        for (int i = 4; i < 15; i++) preload(1'b0, i, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (15) @(negedge clk);
        rd_reg(1, v);
        check("R10 unknown opcode", v, 32'd0);
        rd_reg(2, v);
        check("R10 unknown function", v, 32'd0);
        rd_reg(3, v);
        check("R10 zero function", v, 32'd0);
        rd_mem(5, v);
        check("R10 no store", v, 32'd12);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule